// File: doc/BRIEF.md
# E1 Transmit Frame Formatter

This block produces the serial transmit bit stream of a 2.048 Mbit/s E1 link, one bit per clock. Each frame has 32 timeslots of eight bits each, 256 bits in all, and 16 frames form a multiframe. Payload arrives as an NRZ bit on `ser_in`. The block places the framing content into timeslot 0 and the signaling content into timeslot 16. It counts bit, timeslot, frame and multiframe position itself, or it takes that alignment from a sync pulse.

One control byte sets the behaviour. It picks the source of the timeslot 0 fields, the international bit and the timeslot 16 signaling. It also enables two forced-ones overrides and sets the sync pin's direction and whether the pin marks frames or multiframes. A simple write port loads 16 per-frame signaling bytes and the two timeslot 0 words.

The line runs at a fixed rate, so neither stream side has a valid/ready handshake. A bit is taken on every clock and a bit is produced on every clock, and back-pressure is not possible. The control pins are plain levels that act from the next bit onward.

Top module: `e1tx_formatter`

## Requirements
- R1: The bit counter runs 0 to 255 and wraps. Bit n goes to timeslot n/8 and sends bit (7 - n%8) of that timeslot, so the MSB goes first. `tx_bit` is registered, so a counter position and the `ser_in` value sampled at one clock edge appear on `tx_bit` after that edge. Reset clears `tx_bit` and all counters to 0. The frame number advances by one when the bit counter wraps, and only then.
- R2: In even frames with `ctrl[6]`=0, timeslot bits 6..0 of timeslot 0 come from the alignment word. Its reset value is 0x1B.
- R3: In odd frames with `ctrl[6]`=0, timeslot 0 bit 6 is always 1. Bits 5..0 come from the non-alignment word, whose reset value is 0x00.
- R4: With `ctrl[6]`=1, every bit of timeslot 0 is copied from `ser_in`.
- R5: Timeslot 0 bit 7 is the international bit. With `ctrl[3]`=0 it comes from `ser_in`. With `ctrl[3]`=1 and `ctrl[6]`=0 it is bit 7 of the alignment word in even frames and bit 7 of the non-alignment word in odd frames. With `ctrl[6]`=1, `ctrl[3]` has no effect.
- R6: Timeslot 16 comes from `ser_in` when `ctrl[5]`=0. When `ctrl[5]`=1 it comes from the signaling byte whose index equals the current frame number (0..15).
- R7: With `ctrl[2]`=1, every bit of timeslot 16 is 1, whatever `ctrl[5]` is set to.
- R8: With `ctrl[4]`=1, every output bit is 1. This overrides every other setting.
- R9: When `ctrl[0]`=0 and `ctrl[1]`=0, a high `sync_in` at a clock edge sets the bit counter to 0 and clears bit 0 of the frame number. The next frame is therefore an even frame.
- R10: When `ctrl[0]`=0 and `ctrl[1]`=1, a high `sync_in` sets both the bit counter and the frame number to 0. Without sync, the frame number wraps from 15 to 0.
- R11: When `ctrl[0]`=1, `sync_in` is ignored. `sync_out` is then high exactly while the bit counter is 0, and also requires frame number 0 when `ctrl[1]`=1. When `ctrl[0]`=0, `sync_out` is 0.
- R12: A write with `wr_en`=1 takes effect at that clock edge. Addresses 0..15 load the signaling bytes, 16 loads the alignment word and 17 loads the non-alignment word. All other addresses change nothing. `ctrl[7]` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl | input | 8 | Control byte, bits as in R2 to R12 |
| ser_in | input | 1 | NRZ payload bit |
| sync_in | input | 1 | Alignment pulse, used while `ctrl[0]`=0 |
| sync_out | output | 1 | Boundary marker, driven while `ctrl[0]`=1 |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 5 | Host write address |
| wr_data | input | 8 | Host write data |
| tx_bit | output | 1 | Formatted transmit bit |

## Verification
The bench builds the block with its default parameters: 8-bit timeslots, 32 timeslots per frame and 16 frames per multiframe. At one bit per clock, a full multiframe takes 4096 cycles. That is short enough for one run to walk through every signaling byte and see the frame number wrap from 15 to 0. With these sizes, the sync pulses can land at arbitrary bit offsets in both frame and multiframe mode, and the odd/even alternation of timeslot 0 appears many times within a short run.

// File: rtl/e1tx_pkg.sv
package e1tx_pkg;
  typedef struct packed {
    logic spare;
    logic ts0_pass;
    logic ts16_reg;
    logic all_ones;
    logic si_reg;
    logic sig_ones;
    logic sync_mf;
    logic sync_drive;
  } ctl_t;
endpackage

// File: rtl/e1tx_counters.sv
module e1tx_counters #(
  parameter int FRAME_BITS = 256,
  parameter int MF_LEN     = 16,
  localparam int POS_W     = $clog2(FRAME_BITS),
  localparam int FRM_W     = $clog2(MF_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic             sync_drive,
  input  logic             sync_mf,
  output logic [POS_W-1:0] pos,
  output logic [FRM_W-1:0] frm,
  output logic             sync_out
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
  localparam logic [FRM_W-1:0] LAST_FRM = FRM_W'(MF_LEN - 1);

  logic load;
  assign load = !sync_drive && sync_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
      frm <= '0;
    end else if (load) begin
      pos <= '0;
      frm <= sync_mf ? '0 : {frm[FRM_W-1:1], 1'b0};
    end else if (pos == LAST_POS) begin
      pos <= '0;
      frm <= (frm == LAST_FRM) ? '0 : frm + 1'b1;
    end else begin
      pos <= pos + 1'b1;
    end
  end

  assign sync_out = sync_drive && (pos == '0) && (!sync_mf || frm == '0);

  // R9
  sync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_drive && sync_in) |=> (pos == '0));
  // R10
  mf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_drive && sync_in && sync_mf) |=> (frm == '0));
  // R1
  frm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos != LAST_POS && !(!sync_drive && sync_in)) |=> $stable(frm));
endmodule

// File: rtl/e1tx_regbank.sv
module e1tx_regbank #(
  parameter int N_SIG  = 16,
  parameter int ADDR_W = 5,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] sig_regs [N_SIG],
  output logic [WORD_W-1:0] align_w,
  output logic [WORD_W-1:0] nalign_w
);
  localparam logic [ADDR_W-1:0] ALIGN_ADDR  = ADDR_W'(N_SIG);
  localparam logic [ADDR_W-1:0] NALIGN_ADDR = ADDR_W'(N_SIG + 1);

  for (genvar g = 0; g < N_SIG; g++) begin : g_sig
    always_ff @(posedge clk) begin
      if (!rst_n) sig_regs[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g)) sig_regs[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      align_w  <= WORD_W'(8'h1B);
      nalign_w <= '0;
    end else if (wr_en) begin
      if (wr_addr == ALIGN_ADDR)  align_w  <= wr_data;
      if (wr_addr == NALIGN_ADDR) nalign_w <= wr_data;
    end
  end

  // R12
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > NALIGN_ADDR) |=> ($stable(align_w) && $stable(nalign_w)));
endmodule

// File: rtl/e1tx_bitsel.sv
module e1tx_bitsel #(
  parameter int TS_W    = 8,
  parameter int N_TS    = 32,
  parameter int SIG_TS  = 16,
  localparam int BIT_W  = $clog2(TS_W),
  localparam int TSI_W  = $clog2(N_TS),
  localparam int POS_W  = BIT_W + TSI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ts0_pass,
  input  logic             ts16_reg,
  input  logic             all_ones,
  input  logic             si_reg,
  input  logic             sig_ones,
  input  logic             odd_frame,
  input  logic [POS_W-1:0] pos,
  input  logic             ser_in,
  input  logic [TS_W-1:0]  sig_byte,
  input  logic [TS_W-1:0]  align_w,
  input  logic [TS_W-1:0]  nalign_w,
  output logic             tx_bit
);
  logic [TSI_W-1:0] ts;
  logic [BIT_W-1:0] bsel, idx;
  logic             nxt;

  assign ts   = pos[POS_W-1:BIT_W];
  assign bsel = pos[BIT_W-1:0];
  assign idx  = BIT_W'(TS_W - 1) - bsel;

  always_comb begin
    nxt = ser_in;
    if (all_ones) begin
      nxt = 1'b1;
    end else if (ts == '0) begin
      if (ts0_pass)            nxt = ser_in;
      else if (bsel == '0)     nxt = si_reg ? (odd_frame ? nalign_w[idx] : align_w[idx]) : ser_in;
      else if (!odd_frame)     nxt = align_w[idx];
      else if (bsel == BIT_W'(1)) nxt = 1'b1;
      else                     nxt = nalign_w[idx];
    end else if (ts == TSI_W'(SIG_TS)) begin
      nxt = sig_ones ? 1'b1 : (ts16_reg ? sig_byte[idx] : ser_in);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tx_bit <= 1'b0;
    else        tx_bit <= nxt;
  end

  // R8
  all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_ones |=> tx_bit);
  // R7
  sig_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_ones && ts == TSI_W'(SIG_TS)) |=> tx_bit);
  // R4
  pass_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ts0_pass && !all_ones && ts == '0) |=> (tx_bit == $past(ser_in)));
  // R3
  odd_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ts0_pass && !all_ones && odd_frame && ts == '0 && bsel == BIT_W'(1)) |=> tx_bit);
endmodule

// File: rtl/e1tx_formatter.sv
module e1tx_formatter #(
  parameter int TS_W   = 8,
  parameter int N_TS   = 32,
  parameter int MF_LEN = 16,
  parameter int SIG_TS = 16,
  parameter int ADDR_W = 5,
  localparam int FRAME_BITS = TS_W * N_TS,
  localparam int POS_W      = $clog2(FRAME_BITS),
  localparam int FRM_W      = $clog2(MF_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        ctrl,
  input  logic              ser_in,
  input  logic              sync_in,
  output logic              sync_out,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TS_W-1:0]   wr_data,
  output logic              tx_bit
);
  import e1tx_pkg::*;

  ctl_t             ctl;
  logic             unused_spare;
  logic [POS_W-1:0] pos;
  logic [FRM_W-1:0] frm;
  logic [TS_W-1:0]  sig_regs [MF_LEN];
  logic [TS_W-1:0]  align_w, nalign_w;

  assign ctl          = ctl_t'(ctrl);
  assign unused_spare = ctl.spare;

  e1tx_counters #(.FRAME_BITS(FRAME_BITS), .MF_LEN(MF_LEN)) i_cnt (
    .clk, .rst_n, .sync_in,
    .sync_drive(ctl.sync_drive), .sync_mf(ctl.sync_mf),
    .pos, .frm, .sync_out
  );

  e1tx_regbank #(.N_SIG(MF_LEN), .ADDR_W(ADDR_W), .WORD_W(TS_W)) i_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .sig_regs, .align_w, .nalign_w
  );

  e1tx_bitsel #(.TS_W(TS_W), .N_TS(N_TS), .SIG_TS(SIG_TS)) i_sel (
    .clk, .rst_n,
    .ts0_pass(ctl.ts0_pass), .ts16_reg(ctl.ts16_reg), .all_ones(ctl.all_ones),
    .si_reg(ctl.si_reg), .sig_ones(ctl.sig_ones), .odd_frame(frm[0]),
    .pos, .ser_in, .sig_byte(sig_regs[frm]), .align_w, .nalign_w, .tx_bit
  );

  // R11
  sync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.sync_drive |-> !sync_out);
endmodule

// File: tb/test_e1tx_formatter.sv
module test_e1tx_formatter;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0, ser_in = 1'b0, sync_in = 1'b0, wr_en = 1'b0;
  logic [7:0] ctrl = 8'h00, wr_data = 8'h00;
  logic [4:0] wr_addr = 5'd0;
  logic       sync_out, tx_bit;

  e1tx_formatter i_e1tx_formatter (
    .clk, .rst_n, .ctrl, .ser_in, .sync_in, .sync_out,
    .wr_en, .wr_addr, .wr_data, .tx_bit
  );

  int checks = 0, errors = 0;
  int pos = 0, frm = 0;
  logic [7:0] m_sig [16];
  logic [7:0] m_al = 8'h1B, m_na = 8'h00;
  string tag = "R1";

  task automatic chk(string t, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b (pos %0d frame %0d)", t, act, exp, pos, frm);
    end
  endtask

  task automatic cycle();
    logic e;
    int ts, b;
    @(posedge clk);
    ts = pos / 8; b = pos % 8;
    if (ctrl[4]) e = 1'b1;
    else if (ts == 0) begin
      if (ctrl[6]) e = ser_in;
      else if (b == 0) e = ctrl[3] ? ((frm % 2) ? m_na[7] : m_al[7]) : ser_in;
      else if (frm % 2 == 0) e = m_al[7-b];
      else if (b == 1) e = 1'b1;
      else e = m_na[7-b];
    end else if (ts == 16) e = ctrl[2] ? 1'b1 : (ctrl[5] ? m_sig[frm][7-b] : ser_in);
    else e = ser_in;
    if (wr_en) begin
      if (wr_addr < 16) m_sig[wr_addr] = wr_data;
      else if (wr_addr == 16) m_al = wr_data;
      else if (wr_addr == 17) m_na = wr_data;
    end
    if (!ctrl[0] && sync_in) begin
      pos = 0;
      frm = ctrl[1] ? 0 : (frm & ~1);
    end else begin
      pos = (pos + 1) % 256;
      if (pos == 0) frm = (frm + 1) % 16;
    end
    @(negedge clk);
    chk(tag, tx_bit, e);
    chk("R11", sync_out, ctrl[0] && pos == 0 && (!ctrl[1] || frm == 0));
    ser_in = 1'($urandom); sync_in = 1'b0; wr_en = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cycle();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_sig[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1", tx_bit, 1'b0);
    chk("R11", sync_out, 1'b0);
    rst_n = 1'b1;
    ser_in = 1'($urandom);
    tag = "R1"; run(600);                      // R2 R3 defaults in timeslot 0
    tag = "R12";
    for (int i = 0; i < 16; i++) wr(5'(i), 8'(i * 37 + 5));
    wr(5'd16, 8'h9B); wr(5'd17, 8'h2A);
    wr(5'd20, 8'hFF); wr(5'd31, 8'h00);        // unmapped, no effect
    ctrl = 8'h80; run(300);                    // spare bit ignored
    tag = "R6"; ctrl = 8'h20; run(4200);       // walk every signaling byte
    tag = "R4"; ctrl = 8'h40; run(600);
    tag = "R5"; ctrl = 8'h08; run(600);
    ctrl = 8'h48; run(300);
    tag = "R7"; ctrl = 8'h24; run(600);
    tag = "R8"; ctrl = 8'h7C; run(300);
    tag = "R9"; ctrl = 8'h00; run(37);
    sync_in = 1'b1; cycle(); run(700);
    run(290); sync_in = 1'b1; cycle(); run(300);
    tag = "R10"; ctrl = 8'h22; run(411);
    sync_in = 1'b1; cycle(); run(900);
    tag = "R11"; ctrl = 8'h01; run(100);
    sync_in = 1'b1; cycle(); run(600);
    ctrl = 8'h03; run(50);
    sync_in = 1'b1; cycle(); run(4200);
    summary();
    $finish;
  end
endmodule